// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

This block is a register-mapped SPI master for command/response traffic of the kind serial flash devices use. Software loads a 32-bit command word and up to 32 bytes into an eight-word data buffer. It then programs three bit counts (command, outgoing data, incoming data) and sets a start bit. The block then shifts the command bits out, then the outgoing buffer bits, and then clocks in the requested number of incoming bits. Incoming bits are written back into the same buffer, starting at its first byte. Only SPI mode 0 is produced. SCK runs at the system clock divided by a programmable value from 2 to 4097.

Chip-select lines are controlled directly by a register. This lets a device stay selected across several back-to-back transfers, for example a command transfer followed by several read transfers. A busy flag in the control register tells software when the buffer may be read.

Top module: `spi_hd_master`

## Requirements
- R1: After reset every register reads 0, busy is 0, SCK and MOSI are low and every chip-select output is high.
- R2: Registers sit at byte offsets 0x00 control, 0x04 command word, 0x08..0x24 data buffer words, 0x28 configuration (divider N in bits 27:16, mode bits 5:4, bit-order bit 3), 0x2c bit counts (command 29:24, incoming 20:12, outgoing 8:0), 0x38 chip-select enables. Each register reads back the fields written, and undefined bits read 0.
- R3: Writing 1 to control bit 8 while idle starts a transfer. Control bit 16 (busy) reads 1 from the next cycle for exactly total_bits*(N+2) cycles. A control write with bit 8 clear starts nothing.
- R4: SCK idles low. Each bit spends ceil((N+2)/2) cycles low and then floor((N+2)/2) cycles high. MOSI is low while idle and does not change while SCK is high.
- R5: Phases run in a fixed order: command bits, then outgoing data bits, then incoming bits, with exactly one SCK rising edge per bit.
- R6: Command byte k (k = 0..3) is taken from bits [31-8k:24-8k] of the command word, so the most significant byte goes first.
- R7: Outgoing data byte k is bits [8(k mod 4)+7 : 8(k mod 4)] of the buffer word at 0x08+4*(k/4) (little-endian).
- R8: MISO is sampled when SCK rises. Incoming bit j is stored into buffer byte j/8 using the same little-endian mapping, and buffer bits beyond the incoming count keep their value.
- R9: Within each byte, bit 7 goes first when configuration bit 3 is 0, and bit 0 goes first when it is 1. This holds in all three phases.
- R10: Chip-select output i is low exactly while bit i of 0x38 is 1. It changes only on a write to 0x38 and stays as set across transfers.
- R11: A start with all three counts zero sets busy for exactly one cycle and produces no SCK pulse.
- R12: A start written while busy is ignored: the running transfer keeps its length and bit count.
- R13: Counts saturate on write: a command count above 32 is stored as 32, and data counts above 256 are stored as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | NCS | Chip selects, active low |

## Verification
The bench targets divisors of 2 and 3, where an off-by-one in the half-period timer or a wrong rounding for odd divisors shows up as a busy length or SCK high-time mismatch. It uses counts that are not byte multiples, a full 256-bit buffer in each direction, and LSB-first ordering. A design that swapped the command byte order, mishandled the data byte order or indexed the phases wrongly would return mismatched MOSI streams or buffer words. A partial incoming byte checks that neighbouring buffer bits survive. A zero-length start, a start written mid-transfer and saturating count writes catch a controller that hangs, restarts or overflows its buffer index.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
  localparam int unsigned BUF_WORDS = 8;
  localparam int unsigned BUF_BYTES = BUF_WORDS * 4;
  localparam int unsigned BUF_BITS  = BUF_BYTES * 8;
  localparam int unsigned POS_W     = $clog2(BUF_BITS);
  localparam int unsigned CNT_W     = $clog2(BUF_BITS + 1);
  localparam int unsigned CMD_BITS  = 32;
  localparam int unsigned CMD_CNT_W = 6;
  localparam int unsigned TOT_W     = CNT_W + 1;
  localparam int unsigned DIV_W     = 12;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_BUF  = 8'h08;
  localparam logic [7:0] OFS_CFG  = 8'h28;
  localparam logic [7:0] OFS_CNT  = 8'h2c;
  localparam logic [7:0] OFS_CS   = 8'h38;

  localparam int unsigned START_BIT = 8;
  localparam int unsigned BUSY_BIT  = 16;
  localparam int unsigned DIV_LSB   = 16;
  localparam int unsigned LSBF_BIT  = 3;
  localparam int unsigned CPOL_BIT  = 4;
  localparam int unsigned CPHA_BIT  = 5;
  localparam int unsigned TXN_LSB   = 0;
  localparam int unsigned RXN_LSB   = 12;
  localparam int unsigned CMDN_LSB  = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_FIN} seq_state_e;
  typedef enum logic [1:0] {PH_CMD, PH_TX, PH_RX} phase_e;
endpackage

// File: rtl/spi_hd_regs.sv
module spi_hd_regs
  import spi_hd_pkg::*;
#(
  parameter int unsigned NCS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic                 busy_i,
  input  logic                 rx_we_i,
  input  logic [POS_W-1:0]     rx_pos_i,
  input  logic                 rx_bit_i,
  output logic                 start_o,
  output logic [CMD_BITS-1:0]  cmd_word_o,
  output logic [BUF_BITS-1:0]  buf_o,
  output logic [DIV_W-1:0]     div_o,
  output logic                 lsb_first_o,
  output logic [CMD_CNT_W-1:0] cmd_bits_o,
  output logic [CNT_W-1:0]     tx_bits_o,
  output logic [CNT_W-1:0]     rx_bits_o,
  output logic [NCS-1:0]       cs_en_o
);
  logic [CMD_BITS-1:0]  cmd_q;
  logic [BUF_BITS-1:0]  buf_q;
  logic [DIV_W-1:0]     div_q;
  logic                 lsbf_q, cpol_q, cpha_q;
  logic [CMD_CNT_W-1:0] ncmd_q;
  logic [CNT_W-1:0]     ntx_q, nrx_q;
  logic [NCS-1:0]       cs_q;

  logic [CMD_CNT_W-1:0] ncmd_in;
  logic [CNT_W-1:0]     ntx_in, nrx_in;

  function automatic logic [CNT_W-1:0] sat_data(input logic [CNT_W-1:0] v);
    return (v > CNT_W'(BUF_BITS)) ? CNT_W'(BUF_BITS) : v;
  endfunction

  always_comb begin
    ncmd_in = reg_wdata_i[CMDN_LSB +: CMD_CNT_W];
    if (ncmd_in > CMD_CNT_W'(CMD_BITS)) ncmd_in = CMD_CNT_W'(CMD_BITS);
    ntx_in = sat_data(reg_wdata_i[TXN_LSB +: CNT_W]);
    nrx_in = sat_data(reg_wdata_i[RXN_LSB +: CNT_W]);
  end

  assign start_o = reg_we_i && (reg_addr_i == OFS_CTRL) && reg_wdata_i[START_BIT] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      div_q  <= '0;
      lsbf_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      ncmd_q <= '0;
      ntx_q  <= '0;
      nrx_q  <= '0;
      cs_q   <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFS_CMD) cmd_q <= reg_wdata_i;
      if (reg_addr_i == OFS_CFG) begin
        div_q  <= reg_wdata_i[DIV_LSB +: DIV_W];
        lsbf_q <= reg_wdata_i[LSBF_BIT];
        cpol_q <= reg_wdata_i[CPOL_BIT];
        cpha_q <= reg_wdata_i[CPHA_BIT];
      end
      if (reg_addr_i == OFS_CNT) begin
        ncmd_q <= ncmd_in;
        ntx_q  <= ntx_in;
        nrx_q  <= nrx_in;
      end
      if (reg_addr_i == OFS_CS) cs_q <= reg_wdata_i[NCS-1:0];
    end
  end

  // capture after software write so a shifted-in bit wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else begin
      for (int w = 0; w < BUF_WORDS; w++) begin
        if (reg_we_i && reg_addr_i == OFS_BUF + 8'(4 * w)) buf_q[32*w +: 32] <= reg_wdata_i;
      end
      if (rx_we_i) buf_q[rx_pos_i] <= rx_bit_i;
    end
  end

  logic [31:0] buf_rd [BUF_WORDS];
  logic [BUF_WORDS-1:0] buf_hit;

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_bufrd
    assign buf_rd[w]  = buf_q[32*w +: 32];
    assign buf_hit[w] = (reg_addr_i == OFS_BUF + 8'(4 * w));
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CTRL: reg_rdata_o[BUSY_BIT] = busy_i;
      OFS_CMD:  reg_rdata_o = cmd_q;
      OFS_CFG: begin
        reg_rdata_o[DIV_LSB +: DIV_W] = div_q;
        reg_rdata_o[CPHA_BIT] = cpha_q;
        reg_rdata_o[CPOL_BIT] = cpol_q;
        reg_rdata_o[LSBF_BIT] = lsbf_q;
      end
      OFS_CNT: begin
        reg_rdata_o[CMDN_LSB +: CMD_CNT_W] = ncmd_q;
        reg_rdata_o[RXN_LSB +: CNT_W]      = nrx_q;
        reg_rdata_o[TXN_LSB +: CNT_W]      = ntx_q;
      end
      OFS_CS:   reg_rdata_o[NCS-1:0] = cs_q;
      default: begin
        for (int w = 0; w < BUF_WORDS; w++) begin
          if (buf_hit[w]) reg_rdata_o = buf_rd[w];
        end
      end
    endcase
  end

  assign cmd_word_o  = cmd_q;
  assign buf_o       = buf_q;
  assign div_o       = div_q;
  assign lsb_first_o = lsbf_q;
  assign cmd_bits_o  = ncmd_q;
  assign tx_bits_o   = ntx_q;
  assign rx_bits_o   = nrx_q;
  assign cs_en_o     = cs_q;
endmodule

// File: rtl/spi_hd_tick.sv
module spi_hd_tick
  import spi_hd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             high_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             edge_o
);
  localparam int unsigned PER_W = DIV_W + 1;

  logic [PER_W-1:0] per, hi_len, lo_len, cur_len, cnt_q;

  // odd periods put the extra cycle in the low half
  assign per     = PER_W'(div_i) + PER_W'(2);
  assign hi_len  = per >> 1;
  assign lo_len  = per - hi_len;
  assign cur_len = high_i ? hi_len : lo_len;
  assign edge_o  = run_i && (cnt_q == cur_len - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || edge_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/spi_hd_seq.sv
module spi_hd_seq
  import spi_hd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CMD_CNT_W-1:0] cmd_bits_i,
  input  logic [CNT_W-1:0]     tx_bits_i,
  input  logic [CNT_W-1:0]     rx_bits_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 lsb_first_i,
  input  logic [CMD_BITS-1:0]  cmd_word_i,
  input  logic [BUF_BITS-1:0]  buf_i,
  input  logic                 miso_i,
  input  logic                 edge_i,
  output logic                 run_o,
  output logic                 high_o,
  output logic [DIV_W-1:0]     div_o,
  output logic                 busy_o,
  output logic                 sck_o,
  output logic                 mosi_o,
  output logic                 rx_we_o,
  output logic [POS_W-1:0]     rx_pos_o,
  output logic                 rx_bit_o
);
  seq_state_e st_q;
  phase_e     ph;
  logic [TOT_W-1:0] g_q, tot_q, tot_in, cmd_end, tx_end;
  logic [CMD_CNT_W-1:0] ncmd_q;
  logic [CNT_W-1:0] ntx_q;
  logic [DIV_W-1:0] div_q;
  logic lsbf_q;
  logic [POS_W-1:0] idx;
  logic [2:0] bit_sel;
  logic [4:0] cmd_pos;
  logic [POS_W-1:0] buf_pos;
  logic active, last_bit;

  assign tot_in  = TOT_W'(cmd_bits_i) + TOT_W'(tx_bits_i) + TOT_W'(rx_bits_i);
  assign cmd_end = TOT_W'(ncmd_q);
  assign tx_end  = cmd_end + TOT_W'(ntx_q);

  always_comb begin
    if (g_q < cmd_end) begin
      ph  = PH_CMD;
      idx = POS_W'(g_q);
    end else if (g_q < tx_end) begin
      ph  = PH_TX;
      idx = POS_W'(g_q - cmd_end);
    end else begin
      ph  = PH_RX;
      idx = POS_W'(g_q - tx_end);
    end
  end

  assign bit_sel = lsbf_q ? idx[2:0] : ~idx[2:0];
  // command byte 0 lives in the top byte of the word
  assign cmd_pos = {~idx[4:3], bit_sel};
  assign buf_pos = {idx[POS_W-1:3], bit_sel};

  assign active   = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign last_bit = (g_q == tot_q - TOT_W'(1));

  always_comb begin
    mosi_o = 1'b0;
    if (active) begin
      case (ph)
        PH_CMD:  mosi_o = cmd_word_i[cmd_pos];
        PH_TX:   mosi_o = buf_i[buf_pos];
        default: mosi_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      g_q    <= '0;
      tot_q  <= '0;
      ncmd_q <= '0;
      ntx_q  <= '0;
      div_q  <= '0;
      lsbf_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= (tot_in == '0) ? ST_FIN : ST_LOW;
          g_q    <= '0;
          tot_q  <= tot_in;
          ncmd_q <= cmd_bits_i;
          ntx_q  <= tx_bits_i;
          div_q  <= div_i;
          lsbf_q <= lsb_first_i;
        end
        ST_LOW:  if (edge_i) st_q <= ST_HIGH;
        ST_HIGH: if (edge_i) begin
          if (last_bit) st_q <= ST_IDLE;
          else begin
            st_q <= ST_LOW;
            g_q  <= g_q + TOT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = active;
  assign high_o   = (st_q == ST_HIGH);
  assign div_o    = div_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign sck_o    = (st_q == ST_HIGH);
  assign rx_we_o  = (st_q == ST_LOW) && edge_i && (ph == PH_RX);
  assign rx_pos_o = buf_pos;
  assign rx_bit_o = miso_i;
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
  import spi_hd_pkg::*;
#(
  parameter int unsigned NCS = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_no
);
  logic                 busy, start, rx_we, rx_bit, lsb_first, run, high, edge_q;
  logic [POS_W-1:0]     rx_pos;
  logic [CMD_BITS-1:0]  cmd_word;
  logic [BUF_BITS-1:0]  buf_bits;
  logic [DIV_W-1:0]     div_reg, div_run;
  logic [CMD_CNT_W-1:0] cmd_bits;
  logic [CNT_W-1:0]     tx_bits, rx_bits;
  logic [NCS-1:0]       cs_en;

  spi_hd_regs #(.NCS(NCS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (busy),
    .rx_we_i     (rx_we),
    .rx_pos_i    (rx_pos),
    .rx_bit_i    (rx_bit),
    .start_o     (start),
    .cmd_word_o  (cmd_word),
    .buf_o       (buf_bits),
    .div_o       (div_reg),
    .lsb_first_o (lsb_first),
    .cmd_bits_o  (cmd_bits),
    .tx_bits_o   (tx_bits),
    .rx_bits_o   (rx_bits),
    .cs_en_o     (cs_en)
  );

  spi_hd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_bits_i  (cmd_bits),
    .tx_bits_i   (tx_bits),
    .rx_bits_i   (rx_bits),
    .div_i       (div_reg),
    .lsb_first_i (lsb_first),
    .cmd_word_i  (cmd_word),
    .buf_i       (buf_bits),
    .miso_i      (miso_i),
    .edge_i      (edge_q),
    .run_o       (run),
    .high_o      (high),
    .div_o       (div_run),
    .busy_o      (busy),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .rx_we_o     (rx_we),
    .rx_pos_o    (rx_pos),
    .rx_bit_o    (rx_bit)
  );

  spi_hd_tick u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .high_i (high),
    .div_i  (div_run),
    .edge_o (edge_q)
  );

  assign cs_no = ~cs_en;
endmodule

// File: rtl/spi_hd_chk.sv
module spi_hd_chk #(
  parameter int unsigned NCS = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_we_i,
  input logic [7:0]     reg_addr_i,
  input logic           wr_start_i,
  input logic           busy,
  input logic           sck_o,
  input logic           mosi_o,
  input logic [NCS-1:0] cs_no
);
  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);

  // R4
  mosi_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mosi_o);

  // R4
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> (mosi_o == $past(mosi_o)));

  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 8'h00 && wr_start_i && !busy) |=> busy);

  // R10
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 8'h38) |=> $stable(cs_no));
endmodule

bind spi_hd_master spi_hd_chk #(.NCS(NCS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wr_start_i (reg_wdata_i[8]),
  .busy       (busy),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no)
);

// File: tb/sim_spi_hd_master.sv
`timescale 1ns/1ps
module sim_spi_hd_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [31:0] reg_wdata_i = 32'h0;
  logic [31:0] reg_rdata_o;
  logic        sck_o, mosi_o, miso_i;
  logic [7:0]  cs_no;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  spi_hd_master #(.NCS(8)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_no(cs_no)
  );

  // slave model
  logic clr = 1'b0;
  logic cap [600];
  logic miso_pat [600];
  int   cap_n = 0;
  int   fall_n = 0;

  always @(posedge sck_o or posedge clr) begin
    if (clr) cap_n = 0;
    else begin
      if (cap_n < 600) cap[cap_n] = mosi_o;
      cap_n = cap_n + 1;
    end
  end

  always @(negedge sck_o or posedge clr) begin
    if (clr) fall_n = 0;
    else fall_n = fall_n + 1;
  end

  assign miso_i = (fall_n < 600) ? miso_pat[fall_n] : 1'b0;

  typedef struct packed {
    logic [11:0] div;
    logic        lsb;
    logic [5:0]  ncmd;
    logic [8:0]  ntx;
    logic [8:0]  nrx;
    logic [31:0] cmd;
    logic [31:0] d0;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'd0, 1'b0, 6'd8,  9'd16,  9'd16,  32'hA5123456, 32'h87654321},
    '{12'd1, 1'b1, 6'd32, 9'd8,   9'd8,   32'h0B3C5D6E, 32'h0F1E2D3C},
    '{12'd4, 1'b0, 6'd0,  9'd24,  9'd0,   32'h00000000, 32'hDEADBEEF},
    '{12'd0, 1'b0, 6'd16, 9'd0,   9'd12,  32'h9ABCDEF0, 32'h13579BDF},
    '{12'd2, 1'b1, 6'd5,  9'd3,   9'd4,   32'hC0FFEE11, 32'h2468ACE0},
    '{12'd0, 1'b0, 6'd0,  9'd0,   9'd256, 32'h00000000, 32'h55AA55AA},
    '{12'd0, 1'b1, 6'd0,  9'd256, 9'd0,   32'h00000000, 32'h3C3CA5A5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic clear_slave();
    clr = 1'b1; #1; clr = 1'b0;
  endtask

  task automatic run_xfer(output int bcyc, output int hcyc);
    wr(8'h00, 32'h0000_0100);
    bcyc = 0; hcyc = 0;
    while (reg_rdata_o[16] && bcyc < 20000) begin
      bcyc++;
      if (sck_o) hcyc++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [255:0] eb;
    int bc, hc, n, mis, pos, total, per;

    for (int k = 0; k < 600; k++) miso_pat[k] = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h04, d); chk("R1 cmd", d, 32'h0);
    rd(8'h08, d); chk("R1 buf0", d, 32'h0);
    rd(8'h28, d); chk("R1 cfg", d, 32'h0);
    rd(8'h2c, d); chk("R1 cnt", d, 32'h0);
    rd(8'h38, d); chk("R1 cs reg", d, 32'h0);
    chk("R1 pins", {22'h0, sck_o, mosi_o, cs_no}, {22'h0, 2'b00, 8'hFF});
    @(negedge clk_i);

    // R2 readback, R13 saturation
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, d); chk("R2 cfg", d, 32'h0FFF_0038);
    @(negedge clk_i);
    wr(8'h2c, 32'h1F0F_F0AB); rd(8'h2c, d); chk("R2 cnt", d, 32'h1F0F_F0AB);
    @(negedge clk_i);
    wr(8'h2c, 32'hFFFF_FFFF); rd(8'h2c, d); chk("R13 cnt sat", d, 32'h2010_0100);
    @(negedge clk_i);
    wr(8'h2c, 32'h2010_0100); rd(8'h2c, d); chk("R13 cnt at limit", d, 32'h2010_0100);
    @(negedge clk_i);
    wr(8'h04, 32'hCAFE_F00D); rd(8'h04, d); chk("R2 cmd", d, 32'hCAFE_F00D);
    @(negedge clk_i);
    wr(8'h24, 32'h1234_5678); rd(8'h24, d); chk("R2 buf7", d, 32'h1234_5678);
    @(negedge clk_i);
    wr(8'h3c, 32'hFFFF_FFFF); rd(8'h3c, d); chk("R2 unmapped", d, 32'h0);
    @(negedge clk_i);

    // R10 chip selects
    wr(8'h38, 32'h0000_0005);
    chk("R10 cs low", {24'h0, cs_no}, 32'h0000_00FA);
    rd(8'h38, d); chk("R2 cs reg", d, 32'h5);
    @(negedge clk_i);

    // R3 control write without start bit
    wr(8'h00, 32'hFFFF_FEFF);
    rd(8'h00, d); chk("R3 no start", d, 32'h0);
    @(negedge clk_i);

    // vector table: R3 R4 R5 R6 R7 R8 R9
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      v = VECS[vi];
      per = int'(v.div) + 2;
      total = int'(v.ncmd) + int'(v.ntx) + int'(v.nrx);
      wr(8'h28, {4'h0, v.div, 12'h0, v.lsb, 3'h0});
      wr(8'h04, v.cmd);
      for (int w = 0; w < 8; w++) begin
        eb[32*w +: 32] = v.d0 + 32'(w) * 32'h1111_1111;
        wr(8'(8 + 4 * w), eb[32*w +: 32]);
      end
      wr(8'h2c, {2'b0, v.ncmd, 3'b0, v.nrx, 3'b0, v.ntx});
      for (int k = 0; k < 600; k++) miso_pat[k] = (((k * 7 + vi * 3) % 5) < 2);
      clear_slave();
      run_xfer(bc, hc);
      chk($sformatf("R3 busy cycles v%0d", vi), bc, total * per);
      chk($sformatf("R4 sck high cycles v%0d", vi), hc, total * (per / 2));
      chk($sformatf("R5 sck edges v%0d", vi), cap_n, total);
      mis = 0;
      for (int k = 0; k < int'(v.ncmd); k++) begin
        pos = v.lsb ? (k % 8) : 7 - (k % 8);
        if (cap[k] !== v.cmd[(3 - k / 8) * 8 + pos]) mis++;
      end
      chk($sformatf("R6/R9 cmd bits v%0d", vi), mis, 0);
      mis = 0;
      for (int k = 0; k < int'(v.ntx); k++) begin
        pos = v.lsb ? (k % 8) : 7 - (k % 8);
        if (cap[int'(v.ncmd) + k] !== eb[(k / 8) * 8 + pos]) mis++;
      end
      chk($sformatf("R7/R9 tx bits v%0d", vi), mis, 0);
      for (int k = 0; k < int'(v.nrx); k++) begin
        pos = v.lsb ? (k % 8) : 7 - (k % 8);
        eb[(k / 8) * 8 + pos] = miso_pat[int'(v.ncmd) + int'(v.ntx) + k];
      end
      for (int w = 0; w < 8; w++) begin
        rd(8'(8 + 4 * w), d);
        chk($sformatf("R8 buf word %0d v%0d", w, vi), d, eb[32*w +: 32]);
      end
      @(negedge clk_i);
    end

    // R10 chip select held across transfers, then released
    chk("R10 cs held", {24'h0, cs_no}, 32'h0000_00FA);
    wr(8'h38, 32'h0);
    chk("R10 cs released", {24'h0, cs_no}, 32'h0000_00FF);

    // R11 zero-length start
    wr(8'h2c, 32'h0);
    clear_slave();
    run_xfer(bc, hc);
    chk("R11 busy one cycle", bc, 1);
    chk("R11 no sck", cap_n + hc, 0);
    @(negedge clk_i);

    // R12 start while busy
    wr(8'h28, 32'h0);
    wr(8'h2c, 32'h0800_0000);
    clear_slave();
    wr(8'h00, 32'h0000_0100);
    n = 0;
    repeat (3) begin
      if (reg_rdata_o[16]) n++;
      @(negedge clk_i);
    end
    if (reg_rdata_o[16]) n++;
    wr(8'h00, 32'h0000_0100);
    while (reg_rdata_o[16] && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    chk("R12 busy length", n, 16);
    chk("R12 bit count", cap_n, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule